// File: doc/BRIEF.md
# Push-button power sequencing controller

This block decides when an application's power rail may be switched on and when it must be switched off. It is driven by one active-low push-button and by a power-hold line that the application processor raises once it has started. Two digital flags from external comparators tell it whether the supply is high enough to start and whether it has dropped into undervoltage. All timing is counted in cycles of the block's own clock, so the debounce time, the start-up confirmation window, the reset pulse and the undervoltage grace time are plain parameters.

A debounced press while the rail is off starts a provisional power-up. The enable output goes active and a reset pulse is issued. The power-up only becomes permanent if the processor confirms by raising power-hold inside the window. Otherwise the rail is dropped again. While running, a press raises an interrupt instead of removing power. A separate debounced button output lets software tell a button interrupt from a low-supply interrupt. Power is removed when power-hold falls, or when the supply stays in undervoltage past the grace time. A parameter selects whether confirmation is accepted while the button is still held or only after it has been let go. A second parameter sets the polarity of the enable output.

Top module: `pbctl_top`

## Requirements
- R1: A button change is accepted only after the synchronised input has held its new level for DEBOUNCE_CYC consecutive cycles. A low pulse shorter than that leaves every output as it was. Release is filtered the same way.
- R2: With the rail off, an accepted press starts power-up only when vcc_ok_i is 1. With vcc_ok_i at 0, the enable output stays inactive.
- R3: After power-up starts, the rail stays on if the confirm condition is met within CONFIRM_CYC cycles. Otherwise the enable output returns to inactive once CONFIRM_CYC cycles have passed.
- R4: While running, hold_i at 0 makes the enable output inactive on the next clock edge.
- R5: An accepted press while running sets int_o to 1 and leaves the enable output active.
- R6: pbout_o is 1 exactly while the debounced button is pressed, in every power state.
- R7: vcclo_o is set by a press that is refused for low supply, and cleared when that button is released. It is also set when undervoltage is detected while running.
- R8: rst_o is 1 for the first RST_CYC cycles after the enable output turns active, and 0 at all other times.
- R9: With CHECK_AFTER_RELEASE=1, power-hold confirms only once the debounced button is released, so holding the button through the whole window turns the rail off again. With CHECK_AFTER_RELEASE=0, hold_i confirms even while the button is held.
- R10: Undervoltage while running sets int_o and vcclo_o, and removes power GRACE_CYC cycles later unless hold_i falls first. Shutdown causes rank above the interrupt: hold_i low beats undervoltage, which beats a press. int_o and vcclo_o clear on the edge that turns the rail off.
- R11: en_o is 1 when the rail is on if EN_ACTIVE_HIGH=1. It is 0 when the rail is on if EN_ACTIVE_HIGH=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pb_n | input | 1 | Raw push-button, 0 = pressed |
| hold_i | input | 1 | Power-hold confirmation from the processor |
| vcc_ok_i | input | 1 | Supply above the start threshold |
| vcc_low_i | input | 1 | Supply below the undervoltage threshold |
| en_o | output | 1 | Rail enable, polarity set by EN_ACTIVE_HIGH |
| rst_o | output | 1 | Processor reset, 1 = asserted |
| int_o | output | 1 | Interrupt to the processor |
| pbout_o | output | 1 | Debounced button state, 1 = pressed |
| vcclo_o | output | 1 | Low supply indication |

## Verification
Random low pulses with lengths on both sides of the debounce limit separate accepted presses from ignored bounces, with the supply flag low so that refusals and the low-supply flag are exercised too. Directed sequences cover the remaining paths: a power-up that is never confirmed, one confirmed after release, a press while running, loss of power-hold, and undervoltage with its grace period. A simultaneous power-hold drop and undervoltage shows which shutdown cause wins. Holding the button through the whole window, with power-hold already high, separates the two confirmation variants. Two instances with opposite enable polarity take the same stimulus.

// File: rtl/pbctl_pkg.sv
package pbctl_pkg;
   typedef enum logic [1:0] {
      PS_OFF   = 2'd0,
      PS_START = 2'd1,
      PS_RUN   = 2'd2,
      PS_LOWV  = 2'd3
   } pwr_state_t;
endpackage

// File: rtl/pbctl_debounce.sv
module pbctl_debounce #(
   parameter int SYNC_STAGES  = 2,
   parameter int DEBOUNCE_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_n,
   output logic pressed_o,
   output logic press_evt_o
);
   localparam int CW = $clog2(DEBOUNCE_CYC + 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          run_q;
   logic                   level_q;
   logic                   level_d1_q;
   logic                   sampled_press;

   // metastability chain, idle level is released (1)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_n};
   end

   assign sampled_press = ~sync_q[SYNC_STAGES-1];

   // accept a new level only after an unbroken run of DEBOUNCE_CYC samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= '0;
         level_q <= 1'b0;
      end else if (sampled_press == level_q) begin
         run_q <= '0;
      end else if (run_q == CW'(DEBOUNCE_CYC - 1)) begin
         level_q <= sampled_press;
         run_q   <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d1_q <= 1'b0;
      else        level_d1_q <= level_q;
   end

   assign pressed_o   = level_q;
   assign press_evt_o = level_q & ~level_d1_q;
endmodule

// File: rtl/pbctl_seq.sv
module pbctl_seq
   import pbctl_pkg::*;
#(
   parameter int CONFIRM_CYC         = 40,
   parameter int RST_CYC             = 10,
   parameter int GRACE_CYC           = 20,
   parameter bit CHECK_AFTER_RELEASE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       press_evt,
   input  logic       pb_held,
   input  logic       hold_i,
   input  logic       vcc_ok_i,
   input  logic       vcc_low_i,
   output pwr_state_t state_o,
   output logic       pwr_on,
   output logic       rst_act,
   output logic       fail_start,
   output logic       uv_enter,
   output logic       btn_int,
   output logic       off_enter
);
   localparam int MAXC = (CONFIRM_CYC > GRACE_CYC) ? CONFIRM_CYC : GRACE_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   pwr_state_t    state_q, state_d;
   logic [CW-1:0] win_q;
   logic          confirm_ok;

   generate
      if (CHECK_AFTER_RELEASE) begin : g_after_release
         assign confirm_ok = hold_i & ~pb_held;
      end else begin : g_while_held
         assign confirm_ok = hold_i;
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PS_OFF: begin
            if (press_evt && vcc_ok_i) state_d = PS_START;
         end
         PS_START: begin
            if (confirm_ok)                             state_d = PS_RUN;
            else if (win_q == CW'(CONFIRM_CYC - 1))     state_d = PS_OFF;
         end
         PS_RUN: begin
            if (!hold_i)        state_d = PS_OFF;
            else if (vcc_low_i) state_d = PS_LOWV;
         end
         PS_LOWV: begin
            if (!hold_i || win_q == CW'(GRACE_CYC - 1)) state_d = PS_OFF;
         end
         default: state_d = PS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_OFF;
         win_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_d != state_q)       win_q <= '0;
         else if (win_q != CW'(MAXC))  win_q <= win_q + 1'b1;
      end
   end

   assign state_o    = state_q;
   assign pwr_on     = (state_q != PS_OFF);
   assign rst_act    = (state_q == PS_START) && (win_q < CW'(RST_CYC));
   assign fail_start = (state_q == PS_OFF) && press_evt && !vcc_ok_i;
   assign uv_enter   = (state_q == PS_RUN) && (state_d == PS_LOWV);
   assign btn_int    = (state_q == PS_RUN) && (state_d == PS_RUN) && press_evt;
   assign off_enter  = (state_q != PS_OFF) && (state_d == PS_OFF);
endmodule

// File: rtl/pbctl_flags.sv
module pbctl_flags #(
   parameter bit EN_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_on,
   input  logic rst_act,
   input  logic pb_held,
   input  logic fail_start,
   input  logic uv_enter,
   input  logic btn_int,
   input  logic off_enter,
   output logic en_o,
   output logic rst_o,
   output logic int_o,
   output logic pbout_o,
   output logic vcclo_o
);
   logic int_q;
   logic low_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   int_q <= 1'b0;
      else if (off_enter)           int_q <= 1'b0;
      else if (btn_int || uv_enter) int_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      low_q <= 1'b0;
      else if (off_enter)              low_q <= 1'b0;
      else if (uv_enter || fail_start) low_q <= 1'b1;
      else if (!pwr_on && !pb_held)    low_q <= 1'b0;
   end

   generate
      if (EN_ACTIVE_HIGH) begin : g_en_high
         assign en_o = pwr_on;
      end else begin : g_en_low
         assign en_o = ~pwr_on;
      end
   endgenerate

   assign rst_o   = rst_act;
   assign int_o   = int_q;
   assign pbout_o = pb_held;
   assign vcclo_o = low_q;
endmodule

// File: rtl/pbctl_top.sv
module pbctl_top
   import pbctl_pkg::*;
#(
   parameter int SYNC_STAGES         = 2,
   parameter int DEBOUNCE_CYC        = 1_600_000,
   parameter int CONFIRM_CYC         = 25_000_000,
   parameter int RST_CYC             = 500_000,
   parameter int GRACE_CYC           = 5_000_000,
   parameter bit EN_ACTIVE_HIGH      = 1'b1,
   parameter bit CHECK_AFTER_RELEASE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pb_n,
   input  logic hold_i,
   input  logic vcc_ok_i,
   input  logic vcc_low_i,
   output logic en_o,
   output logic rst_o,
   output logic int_o,
   output logic pbout_o,
   output logic vcclo_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pbctl_top: SYNC_STAGES must be at least 2");
      end
      if (DEBOUNCE_CYC < 1 || GRACE_CYC < 1) begin : g_bad_time
         $error("pbctl_top: DEBOUNCE_CYC and GRACE_CYC must be positive");
      end
      if (CONFIRM_CYC < 2 || RST_CYC >= CONFIRM_CYC) begin : g_bad_window
         $error("pbctl_top: RST_CYC must be shorter than CONFIRM_CYC");
      end
   endgenerate

   logic       pb_held, press_evt;
   pwr_state_t seq_state;
   logic       pwr_on, rst_act, fail_start, uv_enter, btn_int, off_enter;

   pbctl_debounce #(
      .SYNC_STAGES (SYNC_STAGES),
      .DEBOUNCE_CYC(DEBOUNCE_CYC)
   ) u_debounce (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw_n      (pb_n),
      .pressed_o  (pb_held),
      .press_evt_o(press_evt)
   );

   pbctl_seq #(
      .CONFIRM_CYC        (CONFIRM_CYC),
      .RST_CYC            (RST_CYC),
      .GRACE_CYC          (GRACE_CYC),
      .CHECK_AFTER_RELEASE(CHECK_AFTER_RELEASE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .press_evt (press_evt),
      .pb_held   (pb_held),
      .hold_i    (hold_i),
      .vcc_ok_i  (vcc_ok_i),
      .vcc_low_i (vcc_low_i),
      .state_o   (seq_state),
      .pwr_on    (pwr_on),
      .rst_act   (rst_act),
      .fail_start(fail_start),
      .uv_enter  (uv_enter),
      .btn_int   (btn_int),
      .off_enter (off_enter)
   );

   pbctl_flags #(
      .EN_ACTIVE_HIGH(EN_ACTIVE_HIGH)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_on    (pwr_on),
      .rst_act   (rst_act),
      .pb_held   (pb_held),
      .fail_start(fail_start),
      .uv_enter  (uv_enter),
      .btn_int   (btn_int),
      .off_enter (off_enter),
      .en_o      (en_o),
      .rst_o     (rst_o),
      .int_o     (int_o),
      .pbout_o   (pbout_o),
      .vcclo_o   (vcclo_o)
   );
endmodule

// File: rtl/pbctl_chk.sv
module pbctl_chk
   import pbctl_pkg::*;
#(
   parameter bit EN_ACTIVE_HIGH = 1'b1,
   parameter int CONFIRM_CYC    = 40
) (
   input logic       clk,
   input logic       rst_n,
   input logic       hold_i,
   input logic       vcc_ok_i,
   input logic       en_o,
   input logic       rst_o,
   input logic       int_o,
   input pwr_state_t state_q
);
   logic        en_on;
   logic [31:0] start_cnt;

   assign en_on = EN_ACTIVE_HIGH ? en_o : ~en_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    start_cnt <= '0;
      else if (state_q == PS_START)  start_cnt <= start_cnt + 1'b1;
      else                           start_cnt <= '0;
   end

   assert_start_needs_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_OFF && !vcc_ok_i) |=> (state_q == PS_OFF));

   assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_START) |-> (start_cnt < 32'(CONFIRM_CYC)));

   assert_hold_drop_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PS_RUN && !hold_i) |=> !en_on);

   assert_int_only_powered_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> en_on);

   assert_rst_only_powered_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |-> en_on);
endmodule

bind pbctl_top pbctl_chk #(
   .EN_ACTIVE_HIGH(EN_ACTIVE_HIGH),
   .CONFIRM_CYC   (CONFIRM_CYC)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .hold_i  (hold_i),
   .vcc_ok_i(vcc_ok_i),
   .en_o    (en_o),
   .rst_o   (rst_o),
   .int_o   (int_o),
   .state_q (seq_state)
);

// File: tb/pbctl_top_tb.sv
`timescale 1ns/1ps
module pbctl_top_tb;
   localparam int DEB   = 8;
   localparam int CONF  = 40;
   localparam int RSTC  = 10;
   localparam int GRACE = 20;

   logic clk = 1'b0;
   logic rst_n, pb_n, hold, vcc_ok, vcc_low;
   logic en_m, rst_m, int_m, pbout_m, low_m;
   logic en_a, rst_a, int_a, pbout_a, low_a;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   // main: active-low enable, confirm after release
   pbctl_top #(.DEBOUNCE_CYC(DEB), .CONFIRM_CYC(CONF), .RST_CYC(RSTC),
               .GRACE_CYC(GRACE), .EN_ACTIVE_HIGH(1'b0), .CHECK_AFTER_RELEASE(1'b1))
   u_dut (.clk(clk), .rst_n(rst_n), .pb_n(pb_n), .hold_i(hold), .vcc_ok_i(vcc_ok),
          .vcc_low_i(vcc_low), .en_o(en_m), .rst_o(rst_m), .int_o(int_m),
          .pbout_o(pbout_m), .vcclo_o(low_m));

   // alternate: active-high enable, confirm while held
   pbctl_top #(.DEBOUNCE_CYC(DEB), .CONFIRM_CYC(CONF), .RST_CYC(RSTC),
               .GRACE_CYC(GRACE), .EN_ACTIVE_HIGH(1'b1), .CHECK_AFTER_RELEASE(1'b0))
   u_alt (.clk(clk), .rst_n(rst_n), .pb_n(pb_n), .hold_i(hold), .vcc_ok_i(vcc_ok),
          .vcc_low_i(vcc_low), .en_o(en_a), .rst_o(rst_a), .int_o(int_a),
          .pbout_o(pbout_a), .vcclo_o(low_a));

   function automatic logic exp_accept(int len);
      return (len >= DEB);
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   endtask

   task automatic power_up_confirmed();
      hold = 1'b1;
      pb_n = 1'b0; step(DEB + 4);
      pb_n = 1'b1; step(DEB + 6);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         report();
      end
   end

   initial begin
      void'($urandom(32'h5EED_0011));
      pb_n = 1'b1; hold = 1'b0; vcc_ok = 1'b1; vcc_low = 1'b0; rst_n = 1'b0;
      step(3);
      rst_n = 1'b1;
      step(2);

      // reset state and polarity
      chk("R11 main enable idle high", en_m, 1'b1);
      chk("R11 alt enable idle low", en_a, 1'b0);
      chk("R8 reset idle", rst_m, 1'b0);
      chk("R5 int idle", int_m, 1'b0);
      chk("R6 pbout idle", pbout_m, 1'b0);
      chk("R7 vcclo idle", low_m, 1'b0);

      // random bounces around the debounce limit, supply too low to start
      vcc_ok = 1'b0;
      for (int i = 0; i < 20; i++) begin
         int len;
         len = $urandom_range(1, DEB + 2);
         pb_n = 1'b0; step(len);
         pb_n = 1'b1; step(3);
         chk("R1 bounce filter pbout", pbout_m, exp_accept(len));
         chk("R7 refused press flag", low_m, exp_accept(len));
         chk("R2 no start on low supply", en_m, 1'b1);
         step(DEB + 4);
         chk("R7 flag cleared on release", low_m, 1'b0);
      end
      // directed edges of the filter
      pb_n = 1'b0; step(DEB - 1); pb_n = 1'b1; step(3);
      chk("R1 one short of limit", pbout_m, 1'b0);
      step(DEB + 4);
      pb_n = 1'b0; step(DEB); pb_n = 1'b1; step(3);
      chk("R1 exactly at limit", pbout_m, 1'b1);
      step(DEB + 4);
      chk("R1 release filtered", pbout_m, 1'b0);
      vcc_ok = 1'b1;

      // unconfirmed power-up
      hold = 1'b0;
      pb_n = 1'b0; step(DEB + 4);
      chk("R3 provisional enable", en_m, 1'b0);
      chk("R11 alt enable active", en_a, 1'b1);
      chk("R8 reset during start", rst_m, 1'b1);
      pb_n = 1'b1; step(RSTC);
      chk("R8 reset released", rst_m, 1'b0);
      chk("R3 still inside window", en_m, 1'b0);
      step(CONF);
      chk("R3 timeout drops rail", en_m, 1'b1);
      chk("R3 timeout alt", en_a, 1'b0);
      step(DEB);

      // confirmed power-up after release
      pb_n = 1'b0; step(DEB + 4);
      pb_n = 1'b1; hold = 1'b1;
      step(CONF + 10);
      chk("R3 confirmed stays on", en_m, 1'b0);
      chk("R9 alt confirmed", en_a, 1'b1);
      chk("R8 no reset when running", rst_m, 1'b0);

      // press while running
      pb_n = 1'b0; step(DEB + 4);
      chk("R5 interrupt on press", int_m, 1'b1);
      chk("R5 rail kept", en_m, 1'b0);
      chk("R6 pbout while running", pbout_m, 1'b1);
      pb_n = 1'b1; step(DEB + 4);
      chk("R6 pbout released", pbout_m, 1'b0);
      chk("R5 interrupt held", int_m, 1'b1);

      // power-hold drop
      hold = 1'b0; step(1);
      chk("R4 hold drop off", en_m, 1'b1);
      chk("R4 hold drop alt", en_a, 1'b0);
      chk("R10 int cleared at off", int_m, 1'b0);

      // undervoltage with grace period
      power_up_confirmed();
      chk("R3 second power-up", en_m, 1'b0);
      vcc_low = 1'b1; step(2);
      chk("R10 uv interrupt", int_m, 1'b1);
      chk("R7 uv flag", low_m, 1'b1);
      chk("R10 rail during grace", en_m, 1'b0);
      step(GRACE);
      chk("R10 rail off after grace", en_m, 1'b1);
      chk("R10 int cleared", int_m, 1'b0);
      chk("R10 vcclo cleared", low_m, 1'b0);
      vcc_low = 1'b0;

      // hold drop beats undervoltage
      power_up_confirmed();
      vcc_low = 1'b1; hold = 1'b0; step(1);
      chk("R10 priority rail off", en_m, 1'b1);
      chk("R10 priority no interrupt", int_m, 1'b0);
      vcc_low = 1'b0; step(2);

      // confirmation variant with button held through the window
      hold = 1'b1;
      pb_n = 1'b0; step(DEB + 4 + CONF + 5);
      chk("R9 after-release variant timed out", en_m, 1'b1);
      chk("R9 while-held variant on", en_a, 1'b1);
      pb_n = 1'b1; step(DEB + 4);
      chk("R9 release does not restart", en_m, 1'b1);
      chk("R9 alt still on", en_a, 1'b1);
      hold = 1'b0; step(2);
      chk("R4 alt off", en_a, 1'b0);

      done = 1'b1;
      report();
   end
endmodule